// File: doc/BRIEF.md
# Locality-aware host interrupt generator

This block turns a handful of trusted-module status signals into a single level-sensitive host interrupt request. It watches the active locality number with its valid flag, and three status bits: command-ready, status-valid and data-available. It detects the qualifying rising edges of these signals and records each one as a sticky bit in an interrupt-status register. An 8-bit interrupt-enable register selects which of those latched events may raise the interrupt. The output stays high while any enabled event remains latched.

Host software reaches the block through a byte-wide register port with six legacy offsets. Offset 00h is the enable register. Offset 01h is the write-1-to-clear status register. Offset 02h reports which interrupt sources exist. Offsets 03h and 04h are byte views of the status word, and 05h is the data FIFO slot. Any other offset gets no response. Executing commands, the FIFO contents and serial interrupt framing all belong to other blocks.

Top module: `locirq_top`

## Requirements
- R1: After reset, the enable and status registers read 00h and `irq` is low. The previous-input copies also reset to 0, so a status input that is already high when reset is released counts as a rise.
- R2: A 0-to-1 transition of `cmd_rdy` sets status bit 7 on the next clock edge.
- R3: A 0-to-1 transition of `sts_vld` sets status bit 1.
- R4: Status bit 0 is set in two cases: `data_avl` rises while `sts_vld` is 1, or `sts_vld` rises while `data_avl` is already 1. A rise of `data_avl` while `sts_vld` is 0 sets nothing.
- R5: Status bit 2 is set when a locality becomes active, either by seizing control from a different locality or after a cycle with no locality active. It is set only if some locality has been active since reset, so the first locality to become active raises no event.
- R6: Status bits stay set until the host writes a 1 to them at offset 01h. A written 0 leaves a bit unchanged. A new event in the same cycle wins over the clear.
- R7: `irq` is high exactly when (status AND enable) is non-zero. It follows register changes in the cycle after the clock edge that made them.
- R8: Offset 00h holds the enable register. Only bits 7, 2, 1 and 0 are writable. All other bits, including any global enable, read 0.
- R9: The remaining offsets read as follows:
  - 02h reads the constant 87h, and writes to it are ignored.
  - 03h reads `{sts_vld, cmd_rdy, 0, data_avl, 4'b0}`.
  - 04h reads 00h (the burst count is zero).
  - 05h is claimed, reads 00h, and writes to it are ignored.
- R10: A read or write at any offset other than 00h to 05h leaves `reg_claim` low, reads 00h and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| act_loc | input | LOC_W | Number of the currently active locality |
| loc_valid | input | 1 | A locality is currently active |
| cmd_rdy | input | 1 | Command-ready status bit |
| sts_vld | input | 1 | Status-valid bit |
| data_avl | input | 1 | Data-available bit |
| reg_rd | input | 1 | Register read strobe, data returned in the same cycle |
| reg_wr | input | 1 | Register write strobe, applied at the clock edge |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, 00h when not claimed |
| reg_claim | output | 1 | The access hits an implemented offset |
| irq | output | 1 | Level interrupt request to the host |

## Verification
The data-available source is tried in four patterns:
- status-valid rising alone;
- data-available rising under a valid status;
- data-available rising without a valid status;
- status-valid rising onto data that is already present.

Together these separate the two qualified paths from a plain edge detector. The locality source is driven through a first seizure from idle, a direct hand-over between two localities, and a release followed by a new seizure; this shows whether the "previously active" history is honoured. Enable masking, write-1-to-clear with zero and partial masks, and the unclaimed offsets are each followed by readback through the port, so that any stray register update becomes visible.

// File: rtl/locirq_pkg.sv
package locirq_pkg;

  // interrupt event bit positions (shared by enable and status registers)
  localparam int EV_DAV = 0;
  localparam int EV_SV  = 1;
  localparam int EV_LOC = 2;
  localparam int EV_CMD = 7;
  localparam logic [7:0] EV_MASK = 8'h87;

  // positions inside the low status byte view
  localparam int SB_DAV = 4;
  localparam int SB_CMD = 6;
  localparam int SB_SV  = 7;

  // legacy byte offsets
  typedef enum logic [2:0] {
    OFS_IEN  = 3'd0,
    OFS_ISTS = 3'd1,
    OFS_CAPS = 3'd2,
    OFS_STLO = 3'd3,
    OFS_STHI = 3'd4,
    OFS_FIFO = 3'd5
  } ofs_e;
  localparam int OFS_COUNT = 6;

  typedef struct packed {
    logic cmd;
    logic sv;
    logic dav;
    logic loc;
  } ev_t;

endpackage

// File: rtl/locirq_rstsync.sv
module locirq_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/locirq_edge.sv
module locirq_edge
  import locirq_pkg::*;
#(
  parameter int LOC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LOC_W-1:0] act_loc,
  input  logic             loc_valid,
  input  logic             cmd_rdy,
  input  logic             sts_vld,
  input  logic             data_avl,
  output ev_t              ev
);
  localparam int NBIT = 3;

  logic [NBIT-1:0] cur;
  logic [NBIT-1:0] prev_q;
  logic [NBIT-1:0] rise;

  assign cur = {data_avl, sts_vld, cmd_rdy};

  // one previous-value flop and rise detector per status bit
  for (genvar i = 0; i < NBIT; i++) begin : g_rise
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= cur[i];
    end
    assign rise[i] = cur[i] & ~prev_q[i];
  end

  // locality history
  logic [LOC_W-1:0] loc_q;
  logic             lvld_q;
  logic             had_act_q, had_act_d;
  logic             loc_ce;

  assign loc_ce    = loc_valid;
  assign had_act_d = had_act_q | loc_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_q     <= '0;
      lvld_q    <= 1'b0;
      had_act_q <= 1'b0;
    end else begin
      lvld_q    <= loc_valid;
      had_act_q <= had_act_d;
      if (loc_ce) loc_q <= act_loc;
    end
  end

  logic new_owner;
  always_comb begin
    new_owner = loc_valid & (~lvld_q | (act_loc != loc_q));
    ev.cmd    = rise[0];
    ev.sv     = rise[1];
    ev.dav    = (rise[2] & sts_vld) | (rise[1] & data_avl);
    ev.loc    = new_owner & had_act_q;
  end

  a_r4_dav_needs_sv: assert property (@(posedge clk) disable iff (!rst_n)
    ev.dav |-> sts_vld);
  a_r5_loc_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ev.loc |-> loc_valid);
  a_r3_sv_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_vld && !ev.sv) |=> !ev.sv);
endmodule

// File: rtl/locirq_regs.sv
module locirq_regs
  import locirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ev_t        ev,
  input  logic       wr_ien,
  input  logic       wr_ists,
  input  logic [7:0] wdata,
  output logic [7:0] ien,
  output logic [7:0] ists
);
  logic [7:0] ien_q, ien_d;
  logic [7:0] ists_q, ists_d;
  logic [7:0] ev_vec, clr_vec;
  logic       ien_ce, ists_ce;

  always_comb begin
    ev_vec         = '0;
    ev_vec[EV_DAV] = ev.dav;
    ev_vec[EV_SV]  = ev.sv;
    ev_vec[EV_LOC] = ev.loc;
    ev_vec[EV_CMD] = ev.cmd;
    clr_vec        = wr_ists ? (wdata & EV_MASK) : 8'h00;
    ien_ce         = wr_ien;
    ien_d          = wdata & EV_MASK;
    ists_ce        = wr_ists | (|ev_vec);
    ists_d         = (ists_q & ~clr_vec) | ev_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      ists_q <= '0;
    end else begin
      if (ien_ce)  ien_q  <= ien_d;
      if (ists_ce) ists_q <= ists_d;
    end
  end

  assign ien  = ien_q;
  assign ists = ists_q;

  a_r2_cmd_latch: assert property (@(posedge clk) disable iff (!rst_n)
    ev.cmd |=> ists_q[EV_CMD]);
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ists |=> ((ists_q & $past(ists_q)) == $past(ists_q)));
  a_r8_en_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ien |=> $stable(ien_q));
endmodule

// File: rtl/locirq_rdmux.sv
module locirq_rdmux
  import locirq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        ien,
  input  logic [7:0]        ists,
  input  logic              cmd_rdy,
  input  logic              sts_vld,
  input  logic              data_avl,
  output logic [7:0]        rdata,
  output logic              claim,
  output logic              wr_ien,
  output logic              wr_ists
);
  logic hit;
  ofs_e ofs;

  assign hit = (addr < ADDR_W'(OFS_COUNT));
  assign ofs = ofs_e'(addr[2:0]);

  always_comb begin
    claim   = (rd | wr) & hit;
    wr_ien  = wr & hit & (ofs == OFS_IEN);
    wr_ists = wr & hit & (ofs == OFS_ISTS);
    rdata   = '0;
    if (rd && hit) begin
      case (ofs)
        OFS_IEN:  rdata = ien;
        OFS_ISTS: rdata = ists;
        OFS_CAPS: rdata = EV_MASK;
        OFS_STLO: begin
          rdata[SB_SV]  = sts_vld;
          rdata[SB_CMD] = cmd_rdy;
          rdata[SB_DAV] = data_avl;
        end
        default:  rdata = '0;
      endcase
    end
  end

  a_r10_quiet_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
    !claim |-> (rdata == 8'h00 && !wr_ien && !wr_ists));
endmodule

// File: rtl/locirq_top.sv
module locirq_top
  import locirq_pkg::*;
#(
  parameter int LOC_W  = 3,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOC_W-1:0]  act_loc,
  input  logic              loc_valid,
  input  logic              cmd_rdy,
  input  logic              sts_vld,
  input  logic              data_avl,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              reg_claim,
  output logic              irq
);
  logic       rst_i_n;
  ev_t        ev;
  logic [7:0] ien, ists;
  logic       wr_ien, wr_ists;

  locirq_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  locirq_edge #(.LOC_W(LOC_W)) u_edge (
    .clk(clk), .rst_n(rst_i_n), .act_loc(act_loc), .loc_valid(loc_valid),
    .cmd_rdy(cmd_rdy), .sts_vld(sts_vld), .data_avl(data_avl), .ev(ev)
  );

  locirq_regs u_regs (
    .clk(clk), .rst_n(rst_i_n), .ev(ev), .wr_ien(wr_ien), .wr_ists(wr_ists),
    .wdata(reg_wdata), .ien(ien), .ists(ists)
  );

  locirq_rdmux #(.ADDR_W(ADDR_W)) u_mux (
    .clk(clk), .rst_n(rst_i_n), .rd(reg_rd), .wr(reg_wr), .addr(reg_addr),
    .ien(ien), .ists(ists), .cmd_rdy(cmd_rdy), .sts_vld(sts_vld),
    .data_avl(data_avl), .rdata(reg_rdata), .claim(reg_claim),
    .wr_ien(wr_ien), .wr_ists(wr_ists)
  );

  assign irq = |(ists & ien);

  a_r7_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_i_n)
    irq |-> (ien != 8'h00 && ists != 8'h00));
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(rst_i_n) |-> !irq);
endmodule

// File: tb/locirq_top_bench.sv
module locirq_top_bench;
  localparam int K_RD = 0, K_CLM = 1, K_IRQ = 2;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      req;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] act_loc;
  logic       loc_valid, cmd_rdy, sts_vld, data_avl;
  logic       reg_rd, reg_wr;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_claim, irq;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;
  item_t exp_q[$];

  always #4 clk = ~clk;

  locirq_top u_locirq_top (
    .clk(clk), .rst_n(rst_n), .act_loc(act_loc), .loc_valid(loc_valid),
    .cmd_rdy(cmd_rdy), .sts_vld(sts_vld), .data_avl(data_avl),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_claim(reg_claim),
    .irq(irq)
  );

  // monitor: compares queued expectations 2 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (exp_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = exp_q.pop_front();
        case (it.kind)
          K_RD:    act = reg_rdata;
          K_CLM:   act = {7'b0, reg_claim};
          default: act = {7'b0, irq};
        endcase
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic push(int kind, logic [7:0] e, string req);
    item_t it;
    it.kind = kind; it.exp = e; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic rd_reg(logic [7:0] a, logic [7:0] e, logic c, string req);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    push(K_RD, e, req);
    push(K_CLM, {7'b0, c}, req);
    #3 reg_rd = 1'b0;
  endtask

  task automatic wr_reg(logic [7:0] a, logic [7:0] d, logic c, string req);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    push(K_CLM, {7'b0, c}, req);
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic set_in(logic cr, logic sv, logic da, logic lv, logic [2:0] l);
    @(negedge clk);
    cmd_rdy = cr; sts_vld = sv; data_avl = da; loc_valid = lv; act_loc = l;
  endtask

  task automatic chk_irq(logic e, string req);
    @(negedge clk);
    push(K_IRQ, {7'b0, e}, req);
  endtask

  initial begin
    rst_n = 1'b0; act_loc = '0; loc_valid = 0; cmd_rdy = 0; sts_vld = 0;
    data_avl = 0; reg_rd = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_reg(8'h00, 8'h00, 1, "R1 enable after reset");
    rd_reg(8'h01, 8'h00, 1, "R1 status after reset");
    chk_irq(0, "R1 irq after reset");

    // R8 enable writable bits
    wr_reg(8'h00, 8'hFF, 1, "R8 enable write claim");
    rd_reg(8'h00, 8'h87, 1, "R8 enable readback mask");

    // R9 fixed offsets
    rd_reg(8'h02, 8'h87, 1, "R9 capability");
    wr_reg(8'h02, 8'h00, 1, "R9 capability write claim");
    rd_reg(8'h02, 8'h87, 1, "R9 capability after write");
    rd_reg(8'h04, 8'h00, 1, "R9 status high byte");
    wr_reg(8'h05, 8'hA5, 1, "R9 fifo write claim");
    rd_reg(8'h05, 8'h00, 1, "R9 fifo read");
    rd_reg(8'h01, 8'h00, 1, "R9 fifo write no side effect");

    // R2 command ready edge, R7 irq, R6 clear
    set_in(1, 0, 0, 0, 3'd0);
    chk_irq(1, "R7 irq on cmd event");
    rd_reg(8'h01, 8'h80, 1, "R2 cmd-ready latched bit7");
    rd_reg(8'h03, 8'h40, 1, "R9 status low byte cmd");
    wr_reg(8'h01, 8'h00, 1, "R6 write zero claim");
    rd_reg(8'h01, 8'h80, 1, "R6 zero write keeps bit");
    wr_reg(8'h01, 8'h80, 1, "R6 clear claim");
    rd_reg(8'h01, 8'h00, 1, "R6 cleared, level held no re-fire R2");
    chk_irq(0, "R7 irq low after clear");
    set_in(0, 0, 0, 0, 3'd0);

    // R3 / R4 data-available patterns
    set_in(0, 1, 0, 0, 3'd0);
    rd_reg(8'h01, 8'h02, 1, "R3 sv rise alone");
    wr_reg(8'h01, 8'h02, 1, "R6 clear sv");
    set_in(0, 1, 1, 0, 3'd0);
    rd_reg(8'h01, 8'h01, 1, "R4 dav rise under sv");
    rd_reg(8'h03, 8'h90, 1, "R9 status low byte sv+dav");
    wr_reg(8'h01, 8'hFF, 1, "R6 clear all");
    set_in(0, 0, 0, 0, 3'd0);
    set_in(0, 0, 1, 0, 3'd0);
    rd_reg(8'h01, 8'h00, 1, "R4 dav rise without sv ignored");
    set_in(0, 1, 1, 0, 3'd0);
    rd_reg(8'h01, 8'h03, 1, "R4 sv rise onto dav");
    wr_reg(8'h01, 8'h01, 1, "R6 partial clear");
    rd_reg(8'h01, 8'h02, 1, "R6 partial clear leaves bit1");
    wr_reg(8'h01, 8'hFF, 1, "R6 clear all");

    // R5 locality
    set_in(0, 1, 1, 1, 3'd0);
    rd_reg(8'h01, 8'h00, 1, "R5 first seizure no event");
    set_in(0, 1, 1, 1, 3'd3);
    rd_reg(8'h01, 8'h04, 1, "R5 hand-over event");
    wr_reg(8'h01, 8'h04, 1, "R6 clear loc");
    set_in(0, 1, 1, 0, 3'd3);
    rd_reg(8'h01, 8'h00, 1, "R5 release no event");
    set_in(0, 1, 1, 1, 3'd1);
    rd_reg(8'h01, 8'h04, 1, "R5 seize after release");

    // R7 masking
    wr_reg(8'h00, 8'h00, 1, "R7 disable claim");
    chk_irq(0, "R7 masked event no irq");
    wr_reg(8'h00, 8'h04, 1, "R7 enable loc");
    chk_irq(1, "R7 irq after enabling latched event");

    // R10 unclaimed offsets
    rd_reg(8'h06, 8'h00, 0, "R10 offset 06");
    rd_reg(8'h40, 8'h00, 0, "R10 offset 40");
    wr_reg(8'h07, 8'hFF, 0, "R10 write 07 claim");
    rd_reg(8'h00, 8'h04, 1, "R10 enable unchanged");
    rd_reg(8'h01, 8'h04, 1, "R10 status unchanged");
    wr_reg(8'h01, 8'hFF, 1, "R6 final clear");
    chk_irq(0, "R7 irq low at end");

    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    while (!done && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule